// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product as an upper half and a lower half. It does the work one multiplier bit per clock. One 2N-bit register holds the partial product in its upper half and the multiplier bits that are not yet used in its lower half. An N-bit adder with a carry-out adds the multiplicand into the upper half whenever the bit leaving the register is a one. The register then shifts right by one place. The carry enters at the top, and product bits move down into the space the multiplier gives up.

A client pulses the start input while the block is idle and presents both operands in that same cycle. The block stays busy for exactly N cycles. It then raises done for a single cycle. The product stays on the outputs until the next accepted start. A start that arrives while the block is busy is dropped.

Top module: `seq_mul`

## Requirements
- R1: After reset, busy_o and done_o are 0, and hi_o and lo_o both read zero.
- R2: A start_i sampled while the block is idle loads the operands. In the next cycle busy_o is 1, hi_o reads zero and lo_o reads the multiplier.
- R3: Once done_o is 1, {hi_o, lo_o} holds the unsigned product of the two operands, with hi_o carrying bits 2N-1..N and lo_o carrying bits N-1..0.
- R4: busy_o stays high for exactly N consecutive cycles. In the cycle after the last of them, busy_o is 0 and done_o is 1, and done_o is 0 again in the cycle after that.
- R5: A start_i sampled while busy_o is 1 is ignored. The result and the done timing are those of the operation already running.
- R6: While the block is idle and start_i is low, hi_o and lo_o keep their values, even when the operand inputs change.
- R7: The carry out of the N-bit add is kept as the top bit after the shift, so all-ones operands give (2^N-1)^2 in full.
- R8: In an iteration where the bit shifted out is 0, nothing is added, and the register is only shifted right by one place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiply; honoured only when idle |
| mcand_i | input | N | Multiplicand, sampled together with start |
| mplier_i | input | N | Multiplier, sampled together with start |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | Single-cycle pulse when the product is ready |
| hi_o | output | N | Upper half of the product |
| lo_o | output | N | Lower half of the product |

## Verification
The assertions take for granted that start_i and the operands are stable around the clock edge. They also assume the operands only matter in the cycle where start is accepted. The per-iteration checks rely on the block never being restarted from inside a run. The stimulus drives every input on the falling edge. It holds start for one cycle at a time. It sweeps every operand pair at a width of six bits, and it re-asserts start with different operands in the middle of some runs to exercise the ignore rule.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  logic last;

  assign last   = (cnt_q == LAST);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        if (last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // R4: run length and single-cycle done
  a_r4_run_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> busy_o);
  a_r4_run_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && last) |=> (!busy_o && done_o));
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5: start while busy does not restart the count
  a_r5_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last && start_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/seq_mul_step.sv
module seq_mul_step #(
  parameter int unsigned N = 32
) (
  input  logic [2*N-1:0] prod_i,
  input  logic [N-1:0]   mcand_i,
  output logic [2*N-1:0] prod_o
);
  logic [N-1:0] addend;
  logic [N:0]   sum;

  assign addend = prod_i[0] ? mcand_i : '0;
  assign sum    = {1'b0, prod_i[2*N-1:N]} + {1'b0, addend};
  // carry becomes the new top bit after the right shift
  assign prod_o = {sum, prod_i[N-1:1]};
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] hi_o,
  output logic [N-1:0] lo_o
);
  localparam int unsigned PW = 2 * N;

  logic          load, step;
  logic [N-1:0]  mcand_q;
  logic [PW-1:0] prod_q, prod_nxt;

  seq_mul_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  seq_mul_step #(.N(N)) u_step (
    .prod_i (prod_q),
    .mcand_i(mcand_q),
    .prod_o (prod_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= mcand_i;
      prod_q  <= {{N{1'b0}}, mplier_i};
    end else if (step) begin
      prod_q  <= prod_nxt;
    end
  end

  assign hi_o = prod_q[PW-1:N];
  assign lo_o = prod_q[N-1:0];

  // R2: load places multiplier low, clears upper half
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (prod_q == {{N{1'b0}}, $past(mplier_i)}));
  // R6: idle without start keeps the result
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(prod_q));
  // R8: zero bit means plain shift
  a_r8_zero_bit_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !prod_q[0]) |=> (prod_q == ($past(prod_q) >> 1)));
  // R7: top bit after a step never set while upper half plus multiplicand cannot carry
  a_r7_no_spurious_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && prod_q[0] && (({1'b0, hi_o} + {1'b0, mcand_q}) < (N+1)'(2**N)))
      |=> !prod_q[PW-1]);
endmodule

// File: tb/seq_mul_tb.sv
module seq_mul_tb;
  localparam int unsigned W = 6;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] hi_o, lo_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  seq_mul #(.N(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int b, input bit inject, input bit hold);
    logic [2*W-1:0] exp;
    int cyc;
    int guard;
    exp = (2*W)'(a) * (2*W)'(b);
    mcand_i = W'(a);
    mplier_i = W'(b);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R2: loaded state visible after the accepting edge
    check(busy_o && hi_o == 0 && lo_o == W'(b), "R2", {busy_o, hi_o, lo_o}, {1'b1, {W{1'b0}}, W'(b)});
    cyc = 0;
    guard = 0;
    while (!done_o && guard < 4*W) begin
      if (busy_o) cyc++;
      if (inject && cyc == 2) begin
        start_i = 1'b1;      // R5: start during run
        mcand_i = ~W'(a);
        mplier_i = ~W'(b);
      end else begin
        start_i = 1'b0;
      end
      guard++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check(cyc == W && !busy_o, inject ? "R5 R4 length" : "R4 length", cyc, W);
    check({hi_o, lo_o} == exp, inject ? "R5 R3 product" : "R3 product", {hi_o, lo_o}, exp);
    @(negedge clk_i);
    check(!done_o, "R4 done pulse", done_o, 0);
    if (hold) begin
      mcand_i = W'(a + 5);
      mplier_i = W'(b + 3);
      repeat (2) @(negedge clk_i);
      check({hi_o, lo_o} == exp && !busy_o, "R6 hold", {hi_o, lo_o}, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!busy_o && !done_o && hi_o == 0 && lo_o == 0, "R1 reset", {busy_o, done_o, hi_o, lo_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && hi_o == 0 && lo_o == 0, "R1 after release", {busy_o, done_o, hi_o, lo_o}, 0);
    // R7 full carry corner, R8 zero multiplier and multiplicand
    run_op((1 << W) - 1, (1 << W) - 1, 1'b0, 1'b1);
    run_op((1 << W) - 1, 0, 1'b0, 1'b1);
    run_op(0, (1 << W) - 1, 1'b0, 1'b0);
    run_op((1 << W) - 1, 1 << (W - 1), 1'b0, 1'b0);
    run_op(13, 5, 1'b1, 1'b1);
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_op(a, b, ((a + b) % 7) == 0, ((a ^ b) % 11) == 0);
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule